// File: doc/BRIEF.md
# Half-Bridge Gate Command Sequencer

This block sits between a PWM generator and the two gate drivers of one half-bridge leg. It takes a high-side command and a low-side command, both synchronous to the block clock, and turns them into two gate-enable outputs. Each command first passes through a pulse filter. The filter ignores any excursion, high or low, that lasts fewer than a set number of cycles. A deadtime and interlock stage then makes sure the two switches never conduct together. It also holds both switches off for a set time after one of them turns off and before its partner turns on.

A two-bit mode input chooses one of three timing sets. The slow-switch set has a long filter and a long deadtime. The fast-switch set has a short filter and a short deadtime. The pass-through set keeps the long filter but removes both the deadtime and the interlock, so the two outputs follow their filtered commands on their own and may be high together. All times are counted in clock cycles and set by parameters. Both commands count as active-high. After reset both outputs are off, and both filters take the command as low.

Top module: `hb_gate_ctrl`

## Requirements
- R1: While reset is held and after it is released with both commands low, both gate outputs are 0.
- R2: A command excursion that lasts fewer than the active filter length in cycles does not change the output. This holds for a high pulse while the filtered level is low and for a low pulse while it is high.
- R3: A command level held for at least the filter length reaches the filtered stage. Its gate output changes in the (filter length + 1)-th cycle after the command changes, unless the interlock or deadtime delays it.
- R4: The mode input is decoded as follows. 2'b00 is slow-switch timing: filter FILT_IGBT_CYC (20), deadtime DEAD_IGBT_CYC (38). 2'b01 is fast-switch timing: filter FILT_FET_CYC (8), deadtime DEAD_FET_CYC (8). 2'b10 and 2'b11 are pass-through, with filter FILT_IGBT_CYC.
- R5: In modes 2'b00 and 2'b01, after one output falls, the other output is held low for exactly the mode's deadtime in cycles before it may rise. When the partner's request is already waiting, the two outputs are both low for exactly that many cycles.
- R6: In modes 2'b00 and 2'b01, the two outputs are never high in the same cycle.
- R7: In modes 2'b00 and 2'b01, while both filtered commands are high, both outputs are driven low. Once one command falls, the other side is released, subject to R5.
- R8: If the output that turned off turns on again before its partner has turned on, the deadtime starts over from that output's next falling edge.
- R9: In pass-through mode, each output copies its own filtered command one cycle later. There is no deadtime and no interlock, so both outputs may be high together.
- R10: An output falls in the cycle after its filtered command falls, in every mode. No deadtime ever delays a turn-off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Timing set select (see R4) |
| cmd_hi | input | 1 | High-side on command, active high |
| cmd_lo | input | 1 | Low-side on command, active high |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |

## Verification
Random command streams are run in every mode. Their hold lengths are chosen to fall on both sides of the filter length, which separates rejected glitches from accepted transitions and checks the latency of accepted ones. Directed sequences hand control from one side to the other with both commands moving in the same cycle. These measure the gap in which both outputs are low: the full deadtime in the two interlocked modes and zero in pass-through. Holding both commands high tells forced-off interlock apart from pass-through overlap. A low-side output that turns off, turns back on and turns off again shows whether the deadtime restarts from the second turn-off.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    localparam int TIME_W = 16;

    typedef logic [TIME_W-1:0] cyc_t;

    typedef enum logic [1:0] {
        MODE_SLOW   = 2'b00,
        MODE_FAST   = 2'b01,
        MODE_PASS   = 2'b10,
        MODE_PASS_B = 2'b11
    } drv_mode_e;

    typedef struct packed {
        cyc_t filt_len;
        cyc_t dead_len;
        logic pass;
    } timing_t;

    function automatic timing_t pick_timing(drv_mode_e m,
                                            cyc_t filt_slow, cyc_t filt_fast,
                                            cyc_t dead_slow, cyc_t dead_fast);
        timing_t t;
        t.filt_len = filt_slow;
        t.dead_len = dead_slow;
        t.pass     = 1'b0;
        unique case (m)
            MODE_SLOW: ;
            MODE_FAST: begin
                t.filt_len = filt_fast;
                t.dead_len = dead_fast;
            end
            MODE_PASS, MODE_PASS_B: begin
                t.dead_len = '0;
                t.pass     = 1'b1;
            end
            default: ;
        endcase
        return t;
    endfunction

    // Partner may rise once its "off" counter shows dead-1 full cycles.
    function automatic logic dead_done(cyc_t cnt, cyc_t dead);
        return (dead == '0) || (cnt >= dead - cyc_t'(1));
    endfunction

    function automatic logic filt_expired(cyc_t cnt, cyc_t len);
        return (len == '0) || (cnt >= len - cyc_t'(1));
    endfunction

endpackage

// File: rtl/hbg_pulse_filter.sv
module hbg_pulse_filter
    import hbg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cyc_t len,
    input  logic din,
    output logic q
);

    cyc_t run_cnt;
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
            run_cnt <= '0;
        end else if (din == level_q) begin
            run_cnt <= '0;
        end else if (filt_expired(run_cnt, len)) begin
            level_q <= din;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + cyc_t'(1);
        end
    end

    assign q = level_q;

    // R3: the filtered level only ever moves to the value the input had
    p_flip_to_input_r3: assert property (@(posedge clk) disable iff (rst)
        (q != $past(q)) |-> (q == $past(din)));

    // R2: an input matching the filtered level leaves it unchanged
    p_match_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (din == q) |=> $stable(q));

endmodule

// File: rtl/hbg_dead_interlock.sv
module hbg_dead_interlock
    import hbg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pass,
    input  cyc_t       dead,
    input  logic [1:0] req,
    output logic [1:0] gate
);

    localparam int SIDES = 2;

    logic [SIDES-1:0] gate_v;

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        localparam int OTH = SIDES - 1 - s;

        cyc_t off_cnt;   // cycles the partner output has been low
        logic gate_q;
        logic excl_req;
        logic may_rise;

        always_comb begin
            excl_req = req[s] & ~req[OTH];
            may_rise = excl_req & ~gate_v[OTH] & dead_done(off_cnt, dead);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                gate_q  <= 1'b0;
                off_cnt <= '1;
            end else begin
                if (pass) begin
                    gate_q <= req[s];
                end else begin
                    gate_q <= may_rise;
                end
                if (gate_v[OTH]) begin
                    off_cnt <= '0;
                end else if (off_cnt != '1) begin
                    off_cnt <= off_cnt + cyc_t'(1);
                end
            end
        end

        assign gate_v[s] = gate_q;

        // R10: a dropped request turns the output off next cycle
        p_off_next_r10: assert property (@(posedge clk) disable iff (rst)
            !req[s] |=> !gate_v[s]);

        // R5: an interlocked rise never follows a cycle with the partner on
        p_gap_before_rise_r5: assert property (@(posedge clk) disable iff (rst)
            (!$past(pass) && $rose(gate_v[s])) |-> !$past(gate_v[OTH]));
    end

    assign gate = gate_v;

    // R6: no overlap while interlocked
    p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
        (!pass && !$past(pass)) |-> !(gate_v[0] && gate_v[1]));

    // R7: two live requests force both outputs off
    p_both_req_off_r7: assert property (@(posedge clk) disable iff (rst)
        (!pass && req[0] && req[1]) |=> (gate_v == 2'b00));

    // R9: pass-through copies requests one cycle later
    p_pass_copy_r9: assert property (@(posedge clk) disable iff (rst)
        pass |=> (gate_v == $past(req)));

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
    import hbg_pkg::*;
#(
    parameter int FILT_IGBT_CYC = 20,
    parameter int FILT_FET_CYC  = 8,
    parameter int DEAD_IGBT_CYC = 38,
    parameter int DEAD_FET_CYC  = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       cmd_hi,
    input  logic       cmd_lo,
    output logic       gate_hi,
    output logic       gate_lo
);

    localparam int SIDES = 2;
    localparam int SIDE_HI = 0;
    localparam int SIDE_LO = 1;

    timing_t          tim;
    logic [SIDES-1:0] cmd_v;
    logic [SIDES-1:0] filt_v;
    logic [SIDES-1:0] gate_v;

    always_comb begin
        tim = pick_timing(drv_mode_e'(mode),
                          cyc_t'(FILT_IGBT_CYC), cyc_t'(FILT_FET_CYC),
                          cyc_t'(DEAD_IGBT_CYC), cyc_t'(DEAD_FET_CYC));
    end

    assign cmd_v[SIDE_HI] = cmd_hi;
    assign cmd_v[SIDE_LO] = cmd_lo;

    for (genvar s = 0; s < SIDES; s++) begin : g_filt
        hbg_pulse_filter u_filt (
            .clk (clk),
            .rst (rst),
            .len (tim.filt_len),
            .din (cmd_v[s]),
            .q   (filt_v[s])
        );
    end

    hbg_dead_interlock u_seq (
        .clk  (clk),
        .rst  (rst),
        .pass (tim.pass),
        .dead (tim.dead_len),
        .req  (filt_v),
        .gate (gate_v)
    );

    assign gate_hi = gate_v[SIDE_HI];
    assign gate_lo = gate_v[SIDE_LO];

    // R1: outputs are off in the cycle after reset
    p_reset_off_r1: assert property (@(posedge clk)
        rst |=> (!gate_hi && !gate_lo));

endmodule

// File: tb/sim_hb_gate_ctrl.sv
module sim_hb_gate_ctrl;

    localparam int FI = 20, FF = 8, DI = 38, DF = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic cmd_hi = 1'b0, cmd_lo = 1'b0;
    logic gate_hi, gate_lo;

    int checks = 0, errors = 0;

    hb_gate_ctrl u0 (
        .clk(clk), .rst(rst), .mode(mode),
        .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    always #10 clk = ~clk;

    // ---------------- reference model ----------------
    int  cyc;
    bit  mfh, mfl, mh, ml, prev_h, prev_l;
    int  hold_h, hold_l;
    int  hi_off_at, lo_off_at;

    function automatic int filt_of(logic [1:0] m);
        return (m == 2'b01) ? FF : FI;
    endfunction

    function automatic int dead_of(logic [1:0] m);
        return (m == 2'b01) ? DF : DI;
    endfunction

    always @(posedge clk) begin
        bit nh, nl;
        if (rst) begin
            cyc = 0; mfh = 0; mfl = 0; mh = 0; ml = 0;
            prev_h = 0; prev_l = 0; hold_h = 0; hold_l = 0;
            hi_off_at = -100000; lo_off_at = -100000;
        end else begin
            cyc++;
            if (mode[1]) begin
                nh = mfh; nl = mfl;
            end else begin
                nh = mfh && !mfl && !ml && (cyc - lo_off_at >= dead_of(mode));
                nl = mfl && !mfh && !mh && (cyc - hi_off_at >= dead_of(mode));
            end
            if (mh && !nh) hi_off_at = cyc;
            if (ml && !nl) lo_off_at = cyc;
            mh = nh; ml = nl;
            hold_h = (cmd_hi == prev_h) ? hold_h + 1 : 1;
            hold_l = (cmd_lo == prev_l) ? hold_l + 1 : 1;
            prev_h = cmd_hi; prev_l = cmd_lo;
            if (hold_h >= filt_of(mode) && cmd_hi != mfh) mfh = cmd_hi;
            if (hold_l >= filt_of(mode) && cmd_lo != mfl) mfl = cmd_lo;
        end
    end

    // ---------------- checking ----------------
    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    bit saw_hi;

    task automatic tick();
        @(negedge clk);
        if (gate_hi) saw_hi = 1;
        check(mode[1] ? "R9" : "R6", {gate_hi, gate_lo}, {mh, ml}, "gates vs model");
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic idle(input logic [1:0] m);
        cmd_hi = 0; cmd_lo = 0;
        ticks(60);
        mode = m;
        ticks(5);
    endtask

    task automatic latency_hi(output int n);
        n = 0;
        while (!gate_hi && n < 300) begin tick(); n++; end
    endtask

    task automatic measure_gap(output int gap);
        int lim = 0;
        gap = 0;
        while (gate_lo && lim < 300) begin tick(); lim++; end
        while (!gate_hi && lim < 600) begin gap++; tick(); lim++; end
    endtask

    task automatic handover_gap(input logic [1:0] m, output int gap);
        idle(m);
        cmd_lo = 1; ticks(filt_of(m) + 10);
        cmd_lo = 0; cmd_hi = 1;
        measure_gap(gap);
        ticks(5);
    endtask

    initial begin
        #(20 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog R1..: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n, gap;
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        check("R1", {gate_hi, gate_lo}, 0, "outputs during reset");
        rst = 0;
        ticks(3);
        check("R1", {gate_hi, gate_lo}, 0, "outputs after reset");

        // R2: short high and low pulses rejected (fast mode)
        idle(2'b01);
        saw_hi = 0;
        cmd_hi = 1; ticks(FF - 1); cmd_hi = 0; ticks(20);
        check("R2", saw_hi, 0, "short high pulse rejected");
        cmd_hi = 1; ticks(FF + 10);
        check("R2", gate_hi, 1, "long high accepted");
        cmd_hi = 0; ticks(FF - 1); cmd_hi = 1; ticks(20);
        check("R2", gate_hi, 1, "short low pulse rejected");

        // R3/R4 latency per mode
        idle(2'b01); cmd_hi = 1; latency_hi(n);
        check("R3", n, FF + 1, "rise latency fast mode");
        idle(2'b00); cmd_hi = 1; latency_hi(n);
        check("R4", n, FI + 1, "rise latency slow mode");
        idle(2'b10); cmd_hi = 1; latency_hi(n);
        check("R4", n, FI + 1, "rise latency pass mode");
        idle(2'b11); cmd_hi = 1; latency_hi(n);
        check("R4", n, FI + 1, "rise latency pass mode b");

        // R10 turn-off latency
        idle(2'b01); cmd_hi = 1; ticks(FF + 10);
        cmd_hi = 0; n = 0;
        while (gate_hi && n < 300) begin tick(); n++; end
        check("R10", n, FF + 1, "fall latency fast mode");

        // R5 deadtime per interlocked mode; R9 none in pass
        handover_gap(2'b00, gap); check("R5", gap, DI, "both-low gap slow mode");
        handover_gap(2'b01, gap); check("R5", gap, DF, "both-low gap fast mode");
        handover_gap(2'b10, gap); check("R9", gap, 0, "both-low gap pass mode");

        // R7 both requests high
        idle(2'b01);
        cmd_hi = 1; cmd_lo = 1; ticks(FF + 20);
        check("R7", {gate_hi, gate_lo}, 0, "both requested -> both off");
        cmd_lo = 0; ticks(FF + 3);
        check("R7", gate_hi, 1, "released after partner drop");

        // R9 overlap in pass-through
        idle(2'b10);
        cmd_hi = 1; cmd_lo = 1; ticks(FI + 3);
        check("R9", {gate_hi, gate_lo}, 3, "overlap allowed in pass");
        idle(2'b11);
        cmd_hi = 1; cmd_lo = 1; ticks(FI + 3);
        check("R4", {gate_hi, gate_lo}, 3, "mode 2'b11 is pass-through");

        // R8 deadtime restart after re-assert
        idle(2'b00);
        cmd_lo = 1; ticks(FI + 10);
        cmd_lo = 0; ticks(FI + 5);
        check("R8", gate_lo, 0, "low side briefly off");
        cmd_lo = 1; ticks(FI + 5);
        check("R8", gate_lo, 1, "low side back on");
        cmd_lo = 0; cmd_hi = 1;
        measure_gap(gap);
        check("R8", gap, DI, "deadtime counted from second fall");

        // random phase in every mode
        for (int m = 0; m < 4; m++) begin
            idle(m[1:0]);
            for (int s = 0; s < 500; s++) begin
                int pick = $urandom_range(0, 3);
                if (pick == 0 || pick == 2) cmd_hi = ~cmd_hi;
                if (pick == 1 || pick == 2) cmd_lo = ~cmd_lo;
                ticks($urandom_range(1, 45));
            end
        end
        idle(2'b00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule